// File: doc/BRIEF.md
# Reconfigurable split byte timer

The block is a general-purpose timer made of four byte-wide up-counters. A two-bit grouping field chains neighbouring bytes together. The bytes can run as one wide counter, as two half-width counters, as four separate byte counters, or as one half-width counter on the upper pair with the two lower bytes left separate. Each byte has its own reload value and its own run bit. When a group wraps, every byte in that group takes its reload value, and the overflow output of the top byte of the group pulses.

Counting advances on a count-enable tick, and only while the global enable is high. A register-style write port loads all counts or all reload values in one cycle, and both are always visible on output buses. A separate input carries an external clock-line-low timeout event. The block reports that event on the byte-3 overflow output, the same line a byte-3 group wrap uses.

Top module: `split_byte_timer`

## Requirements
- R1: After synchronous reset, all counts, all reload values and all overflow outputs read zero.
- R2: With grouping value 2, each byte is an independent counter that advances by one on a cycle where `tmr_en`, `tick` and that byte's own run bit are all high.
- R3: With grouping value 0, bytes 3,2,1,0 form one counter (byte 0 least significant), and only byte 3 can report its overflow.
- R4: With grouping value 1, bytes {1,0} and bytes {3,2} form two independent counters, whose overflows report on bytes 1 and 3.
- R5: With grouping value 3, bytes {3,2} form one counter, and bytes 0 and 1 count separately.
- R6: When a group is at its all-ones value and advances, every byte of that group loads its reload value in the same cycle. The top byte's bit of `ovf` is high for the following cycle only.
- R7: Inside a group, a byte advances only when every lower byte of the group is all-ones. A lower byte that wraps while the group is not full returns to zero.
- R8: The run bit of the lowest byte of a group gates the whole group. The run bits of the other bytes in the group have no effect.
- R9: When `tmr_en` or `tick` is low, all counts hold.
- R10: A high `scl_low_tmo` makes `ovf[3]` high in the next cycle, whatever the grouping mode and enables.
- R11: `wr_cnt` loads `wdata` (byte b at bits 8b+7:8b) into the counts and takes priority over counting, so no count overflow is reported in that cycle. `wr_rld` loads `wdata` into the reload values, using the same packing.
- R12: `ovf` bits of bytes that are not the top of a group stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | Global timer enable |
| tick | input | 1 | Count-enable tick |
| grp_mode | input | 2 | Grouping: 0 one wide, 1 two halves, 2 four bytes, 3 half plus two bytes |
| run | input | 4 | Per-byte run bits |
| scl_low_tmo | input | 1 | External clock-low timeout event |
| wr_cnt | input | 1 | Write counts from wdata |
| wr_rld | input | 1 | Write reload values from wdata |
| wdata | input | 32 | Write data, byte b at bits 8b+7:8b |
| cnt_q | output | 32 | Current counts, same packing |
| rld_q | output | 32 | Reload values, same packing |
| ovf | output | 4 | Per-byte overflow pulses |

## Verification
The bench builds the block with its default byte width of 8 and four bytes, so a full 32-bit group would need billions of ticks to wrap. Because the write port can preload counts just below the all-ones value, the wraps of all four groupings come within a few hundred cycles. A pseudo-random tick and run pattern then exercises carries that are cut off part-way through a chain, and non-head run bits that must have no effect.

// File: rtl/split_tmr_pkg.sv
package split_tmr_pkg;

    localparam int NB = 4;

    typedef enum logic [1:0] {
        GRP_ONE_WIDE  = 2'd0,
        GRP_TWO_HALF  = 2'd1,
        GRP_FOUR_BYTE = 2'd2,
        GRP_HALF_PAIR = 2'd3
    } grp_mode_e;

    typedef struct packed {
        logic head;   // lowest byte of its group
        logic top;    // highest byte of its group
        logic linked; // takes carry from the byte below
    } byte_role_t;

    // bit b set: byte b is chained to byte b-1
    function automatic logic [NB-1:0] link_map(grp_mode_e m);
        case (m)
            GRP_ONE_WIDE:  return 4'b1110;
            GRP_TWO_HALF:  return 4'b1010;
            GRP_FOUR_BYTE: return 4'b0000;
            default:       return 4'b1000;
        endcase
    endfunction

endpackage

// File: rtl/tmr_group_map.sv
module tmr_group_map
    import split_tmr_pkg::*;
(
    input  logic [1:0]                grp_mode,
    output byte_role_t [NB-1:0]       role
);
    logic [NB-1:0] link;

    assign link = link_map(grp_mode_e'(grp_mode));

    for (genvar b = 0; b < NB; b++) begin : g_role
        assign role[b].linked = link[b];
        assign role[b].head   = ~link[b];
        if (b == NB - 1) begin : g_last
            assign role[b].top = 1'b1;
        end else begin : g_mid
            assign role[b].top = ~link[b+1];
        end
    end
endmodule

// File: rtl/tmr_byte_cell.sv
module tmr_byte_cell #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_val,
    input  logic [BW-1:0] rld_val,
    input  logic          inc,
    input  logic          rel,
    output logic [BW-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (wr_en)   cnt_q <= wr_val;
        else if (rel)     cnt_q <= rld_val;
        else if (inc)     cnt_q <= cnt_q + 1'b1;
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !inc && !rel) |=> cnt_q == $past(cnt_q));

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && inc && !rel) |=> cnt_q == $past(cnt_q) + 1'b1);

    p_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && rel) |=> cnt_q == $past(rld_val));

    p_write_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt_q == $past(wr_val));
endmodule

// File: rtl/split_byte_timer.sv
module split_byte_timer
    import split_tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tmr_en,
    input  logic                 tick,
    input  logic [1:0]           grp_mode,
    input  logic [3:0]           run,
    input  logic                 scl_low_tmo,
    input  logic                 wr_cnt,
    input  logic                 wr_rld,
    input  logic [4*BYTE_W-1:0]  wdata,
    output logic [4*BYTE_W-1:0]  cnt_q,
    output logic [4*BYTE_W-1:0]  rld_q,
    output logic [3:0]           ovf
);
    localparam int W = NB * BYTE_W;

    byte_role_t [NB-1:0] role;
    logic [NB-1:0]       full, inc_c, rel_c;
    logic                act;

    tmr_group_map u_map (.grp_mode(grp_mode), .role(role));

    assign act = tmr_en & tick;

    always_comb begin
        for (int b = 0; b < NB; b++)
            full[b] = &cnt_q[b*BYTE_W +: BYTE_W];
        inc_c = '0;
        for (int b = 0; b < NB; b++) begin
            if (role[b].head || b == 0) inc_c[b] = act & run[b];
            else                        inc_c[b] = inc_c[b-1] & full[b-1];
        end
        rel_c = '0;
        for (int b = NB - 1; b >= 0; b--) begin
            if (role[b].top || b == NB - 1) rel_c[b] = inc_c[b] & full[b];
            else                            rel_c[b] = rel_c[b+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rld_q <= '0;
        else if (wr_rld) rld_q <= wdata;
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte
        tmr_byte_cell #(.BW(BYTE_W)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_cnt),
            .wr_val (wdata[b*BYTE_W +: BYTE_W]),
            .rld_val(rld_q[b*BYTE_W +: BYTE_W]),
            .inc    (inc_c[b]),
            .rel    (rel_c[b]),
            .cnt_q  (cnt_q[b*BYTE_W +: BYTE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= '0;
        end else begin
            for (int b = 0; b < NB; b++)
                ovf[b] <= ~wr_cnt & role[b].top & inc_c[b] & full[b];
            if (scl_low_tmo) ovf[NB-1] <= 1'b1;
        end
    end

    for (genvar b = 0; b < NB - 1; b++) begin : g_chk
        p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
            ovf[b] |-> $past(role[b].top));
    end

    p_tmo_r10: assert property (@(posedge clk) disable iff (rst)
        scl_low_tmo |=> ovf[NB-1]);

    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf[0] && !$past(scl_low_tmo)) |-> $past(act));

    initial assert (W == 32) else $error("width");
endmodule

// File: tb/tb_split_byte_timer.sv
module tb_split_byte_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst = 1, tmr_en = 0, tick = 0, scl_low_tmo = 0;
    logic        wr_cnt = 0, wr_rld = 0;
    logic [1:0]  grp_mode = 0;
    logic [3:0]  run = 0;
    logic [31:0] wdata = 0, cnt_q, rld_q;
    logic [3:0]  ovf;

    split_byte_timer dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0, cyc = 0;
    string tag = "R1";
    logic [7:0]  mb [4];
    logic [31:0] mr;
    logic [3:0]  movf;
    bit rnd_tick = 0, rnd_run = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int grp_top(logic [1:0] m, int lo);
        case (m)
            2'd0: return 3;
            2'd1: return lo + 1;
            2'd2: return lo;
            default: return (lo == 2) ? 3 : lo;
        endcase
    endfunction

    task automatic check(string t, logic [31:0] act_v, logic [31:0] exp_v, string what);
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", t, what, act_v, exp_v, cyc);
        end
    endtask

    always @(posedge clk) begin
        logic [7:0] nb [4];
        logic [3:0] no;
        longint unsigned v, mx;
        int hi;
        cyc++;
        if (rst) begin
            for (int k = 0; k < 4; k++) mb[k] = 0;
            mr = 0; movf = 0;
        end else begin
            nb = mb; no = 0;
            if (wr_cnt) begin
                for (int k = 0; k < 4; k++) nb[k] = wdata[8*k +: 8];
            end else begin
                for (int lo = 0; lo < 4; lo = hi + 1) begin
                    hi = grp_top(grp_mode, lo);
                    v = 0;
                    for (int k = hi; k >= lo; k--) v = (v << 8) | mb[k];
                    mx = (64'd1 << (8 * (hi - lo + 1))) - 1;
                    if (tmr_en && tick && run[lo]) begin
                        if (v == mx) begin
                            for (int k = lo; k <= hi; k++) nb[k] = mr[8*k +: 8];
                            no[hi] = 1'b1;
                        end else begin
                            v = v + 1;
                            for (int k = lo; k <= hi; k++) nb[k] = 8'(v >> (8 * (k - lo)));
                        end
                    end
                end
            end
            if (scl_low_tmo) no[3] = 1'b1;
            if (wr_rld) mr = wdata;
            mb = nb; movf = no;
        end
        #2;
        check(tag, cnt_q, {mb[3], mb[2], mb[1], mb[0]}, "count");
        check(tag, rld_q, mr, "reload");
        check((tag == "R1") ? "R1" : "R12", {28'd0, ovf}, {28'd0, movf}, "ovf");
    end

    task automatic step(int n);
        repeat (n) @(negedge clk) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (rnd_tick) tick = lfsr[0];
            if (rnd_run)  run  = lfsr[7:4];
        end
    endtask

    task automatic wr(bit cnt, logic [31:0] d);
        @(negedge clk);
        wdata = d; wr_cnt = cnt; wr_rld = !cnt;
        @(negedge clk);
        wr_cnt = 0; wr_rld = 0;
    endtask

    initial begin
        step(3);
        rst = 0;
        tag = "R1"; step(2);
        // R11: reload and count writes, R2 independent bytes, R6 reload on wrap
        tag = "R11"; wr(0, 32'h10203040); wr(1, 32'hFEFDFCFB);
        tag = "R2"; grp_mode = 2; tmr_en = 1; tick = 1; run = 4'hF; step(12);
        tag = "R6"; step(10);
        // R11: write during counting wins
        tag = "R11"; @(negedge clk); wdata = 32'h000000FF; wr_cnt = 1;
        @(negedge clk); wr_cnt = 0; step(3);
        // R9: global enable and tick low
        tag = "R9"; tmr_en = 0; step(8); tmr_en = 1; tick = 0; step(8);
        tag = "R2"; rnd_tick = 1; rnd_run = 1; step(300);
        // R3 one wide counter
        rnd_run = 0; run = 4'h1; tick = 1; rnd_tick = 0;
        tag = "R3"; grp_mode = 0; wr(1, 32'hFFFFFFF0); step(40);
        tag = "R7"; wr(1, 32'h00FFFEF0); rnd_tick = 1; step(600);
        // R8: non-head run bits do not matter, head bit stops the group
        tag = "R8"; rnd_tick = 0; tick = 1; run = 4'hE; step(10);
        run = 4'h1; step(5); rnd_run = 1; step(200); rnd_run = 0;
        // R4 two halves
        tag = "R4"; grp_mode = 1; run = 4'h5; wr(1, 32'hFFF0FFF8); step(40);
        rnd_run = 1; rnd_tick = 1; step(400); rnd_run = 0;
        // R5 half plus two bytes
        tag = "R5"; grp_mode = 3; run = 4'h7; rnd_tick = 0; tick = 1;
        wr(1, 32'hFFF8F0FA); step(40);
        rnd_run = 1; rnd_tick = 1; step(500); rnd_run = 0;
        // R10 external timeout in every mode, counting or not
        tag = "R10";
        for (int m = 0; m < 4; m++) begin
            grp_mode = 2'(m);
            @(negedge clk); scl_low_tmo = 1; @(negedge clk); scl_low_tmo = 0; step(3);
        end
        tmr_en = 0; @(negedge clk); scl_low_tmo = 1; @(negedge clk); scl_low_tmo = 0; step(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule